// File: doc/BRIEF.md
# Flash Write Protection Gate

This block stands between the bus strobes of a NOR-style flash model and its command state machine. It decides whether each bus write cycle reaches the command logic. It also decides whether a program or erase request aimed at one sector may proceed. Strobes are cleaned by a stable-for-N-clocks filter. The device reset pin is qualified by a minimum low width. Writes are blocked while the supply is below its threshold, during power-up and during a qualified reset.

A write-protect pin, active low, locks one outermost sector regardless of that sector's stored protection bit. A parameter chooses whether the highest or the lowest sector is the protected one. The pin level is captured when a command sequence starts and is held until the next start. Entering any inhibit condition sends a one-cycle pulse that returns the command logic to array-read mode. A qualified reset also places the data outputs in high impedance.

Top module: `flash_wr_guard`

## Requirements
- R1: A write is accepted (one-cycle `wr_accept`) when filtered WE# falls while filtered CE# is low and filtered OE# is high, and filtered WE# then rises while CE# is still low. The pulse comes one clock after the filtered rise.
- R2: A level change on `pin_ce_n`, `pin_we_n` or `pin_oe_n` takes effect only after it has held for `GLITCH_CLKS` consecutive clocks. A shorter pulse starts no write.
- R3: The boundary sector is sector `NSECT-1` when `BOUNDARY` is top, and sector 0 when it is bottom. While the captured write-protect level is 0, a request to the boundary sector gets `pe_reject` even if its stored bit is 0.
- R4: While the captured level is 1, every sector, the boundary sector included, is granted exactly when its `sect_prot` bit is 0.
- R5: `wp_n` is captured in the cycle that `cmd_start` is high, and that same cycle uses the new value. Later changes of `wp_n` have no effect until the next `cmd_start`.
- R6: While `supply_ok` is 0, no write is accepted and every request gets `pe_reject`.
- R7: While `pwr_up` is 1, no write is accepted. A WE# low that is held from power-up does not count as a write when it rises after `pwr_up` falls.
- R8: When `pin_rst_n` has been low for `RST_MIN_CLKS` consecutive clocks, `out_hiz` rises. From then until the pin goes high, writes are ignored and requests are rejected. `out_hiz` falls one clock after the pin is sampled high.
- R9: A `pin_rst_n` low pulse shorter than `RST_MIN_CLKS` clocks leaves `out_hiz` at 0.
- R10: `force_read` pulses for one clock whenever the inhibit condition (supply low, power-up or qualified reset) becomes true.
- R11: Each `pe_req` cycle produces exactly one of `pe_grant` or `pe_reject`, one clock later. After system reset the captured level is 1, which means no lock by the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, asynchronous, active low |
| pin_ce_n | input | 1 | Chip enable strobe, active low |
| pin_we_n | input | 1 | Write enable strobe, active low |
| pin_oe_n | input | 1 | Output enable strobe, active low |
| pin_rst_n | input | 1 | Device reset pin, active low, width qualified |
| wp_n | input | 1 | Write-protect pin, active low |
| supply_ok | input | 1 | Supply above lockout threshold |
| pwr_up | input | 1 | Power-up in progress |
| sect_prot | input | NSECT | Stored protection bit per sector, 1 = protected |
| cmd_start | input | 1 | Command sequence begins this cycle |
| pe_req | input | 1 | Program/erase request this cycle |
| pe_sector | input | $clog2(NSECT) | Target sector of the request |
| wr_accept | output | 1 | One-cycle write-accepted strobe |
| pe_grant | output | 1 | Request permitted |
| pe_reject | output | 1 | Request refused |
| force_read | output | 1 | One-cycle return-to-read pulse |
| out_hiz | output | 1 | Data outputs to high impedance |

## Verification
The assertions assume that the strobe, reset-pin and request inputs change only between clock edges, and that `pe_req` is a single-cycle pulse with a valid sector number. They also assume that `wp_n` is not driven by anything that could be X after reset. The bench drives every input on the falling clock edge and holds each strobe level for whole cycles. It keeps each request to one cycle with a sector below `NSECT`, so the filters and the captured protect level see clean, synchronous values.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  typedef enum logic {BOUND_BOTTOM = 1'b0, BOUND_TOP = 1'b1} bound_e;
endpackage

// File: rtl/fg_stable_filter.sv
module fg_stable_filter #(
  parameter int unsigned GLITCH_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  localparam int unsigned CW = (GLITCH_CLKS > 1) ? $clog2(GLITCH_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(GLITCH_CLKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          filt_q, filt_d;

  always_comb begin
    cnt_d  = cnt_q;
    filt_d = filt_q;
    if (raw == filt_q) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      filt_d = raw;
      cnt_d  = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      filt_q <= filt_d;
    end
  end

  assign filt = filt_q;

  // R2: a filtered change always reflects the raw level of the previous cycle
  assert_filter_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> ($past(raw) == filt_q));
endmodule

// File: rtl/fg_reset_qual.sv
module fg_reset_qual #(
  parameter int unsigned RST_MIN_CLKS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_rst_n,
  output logic dev_rst
);
  localparam int unsigned CW = (RST_MIN_CLKS > 1) ? $clog2(RST_MIN_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(RST_MIN_CLKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          dev_q, dev_d;

  always_comb begin
    cnt_d = cnt_q;
    dev_d = dev_q;
    if (pin_rst_n) begin
      cnt_d = '0;
      dev_d = 1'b0;
    end else if (cnt_q == LAST) begin
      dev_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dev_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dev_q <= dev_d;
    end
  end

  assign dev_rst = dev_q;

  // R8: qualified reset only rises after the pin was sampled low
  assert_reset_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_q) |-> !$past(pin_rst_n));
  // R9: qualified reset never outlives a high sample of the pin
  assert_reset_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pin_rst_n |=> !dev_q);
endmodule

// File: rtl/fg_sector_gate.sv
module fg_sector_gate #(
  parameter int unsigned NSECT = 8,
  parameter flash_guard_pkg::bound_e BOUNDARY = flash_guard_pkg::BOUND_TOP,
  localparam int unsigned SW = $clog2(NSECT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wp_n,
  input  logic             cmd_start,
  input  logic             pe_req,
  input  logic [SW-1:0]    pe_sector,
  input  logic [NSECT-1:0] sect_prot,
  input  logic             inhibit,
  output logic             pe_grant,
  output logic             pe_reject
);
  localparam logic [SW-1:0] BSECT =
    (BOUNDARY == flash_guard_pkg::BOUND_TOP) ? SW'(NSECT - 1) : '0;

  logic wp_lat_q, wp_lat_d, wp_use;
  logic grant_q, grant_d, rej_q, rej_d, locked;

  always_comb begin
    wp_use   = cmd_start ? wp_n : wp_lat_q;
    wp_lat_d = wp_use;
    locked   = sect_prot[pe_sector] | ((pe_sector == BSECT) & ~wp_use);
    grant_d  = pe_req & ~locked & ~inhibit;
    rej_d    = pe_req & (locked | inhibit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_lat_q <= 1'b1;
      grant_q  <= 1'b0;
      rej_q    <= 1'b0;
    end else begin
      wp_lat_q <= wp_lat_d;
      grant_q  <= grant_d;
      rej_q    <= rej_d;
    end
  end

  assign pe_grant  = grant_q;
  assign pe_reject = rej_q;

  // R11: one verdict per request, never both
  assert_one_verdict_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pe_req |=> (pe_grant ^ pe_reject));
  assert_no_spurious_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !pe_req |=> !(pe_grant || pe_reject));
  // R4: a stored protection bit always refuses
  assert_prot_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_req && sect_prot[pe_sector]) |=> pe_reject);
  // R3: pin low at sequence start locks the boundary sector
  assert_boundary_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_req && cmd_start && !wp_n && pe_sector == BSECT) |=> !pe_grant);
endmodule

// File: rtl/flash_wr_guard.sv
module flash_wr_guard #(
  parameter int unsigned NSECT        = 8,
  parameter int unsigned GLITCH_CLKS  = 4,
  parameter int unsigned RST_MIN_CLKS = 6,
  parameter flash_guard_pkg::bound_e BOUNDARY = flash_guard_pkg::BOUND_TOP,
  localparam int unsigned SW = $clog2(NSECT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_ce_n,
  input  logic             pin_we_n,
  input  logic             pin_oe_n,
  input  logic             pin_rst_n,
  input  logic             wp_n,
  input  logic             supply_ok,
  input  logic             pwr_up,
  input  logic [NSECT-1:0] sect_prot,
  input  logic             cmd_start,
  input  logic             pe_req,
  input  logic [SW-1:0]    pe_sector,
  output logic             wr_accept,
  output logic             pe_grant,
  output logic             pe_reject,
  output logic             force_read,
  output logic             out_hiz
);
  localparam int unsigned NSTROBE = 3;

  logic [NSTROBE-1:0] raw_strobe, filt_strobe;
  logic ce_f, we_f, oe_f, dev_rst, inhibit;
  logic we_q, armed_q, armed_d, acc_q, acc_d, inh_q, frc_q, frc_d;
  logic we_fall, we_rise;

  assign raw_strobe = {pin_oe_n, pin_we_n, pin_ce_n};

  for (genvar g = 0; g < NSTROBE; g++) begin : g_filt
    fg_stable_filter #(.GLITCH_CLKS(GLITCH_CLKS)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw(raw_strobe[g]), .filt(filt_strobe[g]));
  end

  assign ce_f = filt_strobe[0];
  assign we_f = filt_strobe[1];
  assign oe_f = filt_strobe[2];

  fg_reset_qual #(.RST_MIN_CLKS(RST_MIN_CLKS)) u_rq (
    .clk(clk), .rst_n(rst_n), .pin_rst_n(pin_rst_n), .dev_rst(dev_rst));

  assign inhibit = dev_rst | ~supply_ok | pwr_up;

  fg_sector_gate #(.NSECT(NSECT), .BOUNDARY(BOUNDARY)) u_gate (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_start(cmd_start),
    .pe_req(pe_req), .pe_sector(pe_sector), .sect_prot(sect_prot),
    .inhibit(inhibit), .pe_grant(pe_grant), .pe_reject(pe_reject));

  always_comb begin
    we_fall = ~we_f & we_q;
    we_rise = we_f & ~we_q;
    armed_d = armed_q;
    if (inhibit || we_rise) begin
      armed_d = 1'b0;
    end else if (we_fall && !ce_f && oe_f) begin
      armed_d = 1'b1;
    end
    acc_d = we_rise & armed_q & ~ce_f & ~inhibit;
    frc_d = inhibit & ~inh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b1;
      armed_q <= 1'b0;
      acc_q   <= 1'b0;
      inh_q   <= 1'b0;
      frc_q   <= 1'b0;
    end else begin
      we_q    <= we_f;
      armed_q <= armed_d;
      acc_q   <= acc_d;
      inh_q   <= inhibit;
      frc_q   <= frc_d;
    end
  end

  assign wr_accept  = acc_q;
  assign force_read = frc_q;
  assign out_hiz    = dev_rst;

  // R6, R7, R8: no write is accepted right after an inhibited cycle
  assert_no_write_inhibit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> !wr_accept);
  // R1: the accept strobe lasts one cycle
  assert_accept_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> !wr_accept);
  // R10: the return-to-read pulse lasts one cycle
  assert_force_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    force_read |=> !force_read);
  // R6: requests are refused while the supply is low
  assert_supply_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_req && !supply_ok) |=> pe_reject);
endmodule

// File: tb/sim_flash_wr_guard.sv
module sim_flash_wr_guard;
  localparam int NSECT = 8;
  localparam int GC    = 4;
  localparam int RMIN  = 6;
  localparam int SW    = $clog2(NSECT);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_ce_n = 1'b1, pin_we_n = 1'b1, pin_oe_n = 1'b1, pin_rst_n = 1'b1;
  logic wp_n = 1'b1, supply_ok = 1'b1, pwr_up = 1'b0, cmd_start = 1'b0;
  logic pe_req = 1'b0;
  logic [SW-1:0] pe_sector = '0;
  logic [NSECT-1:0] sect_prot = '0;
  logic wr_accept, pe_grant, pe_reject, force_read, out_hiz;

  always #2 clk = ~clk;

  flash_wr_guard #(.NSECT(NSECT), .GLITCH_CLKS(GC), .RST_MIN_CLKS(RMIN),
                   .BOUNDARY(flash_guard_pkg::BOUND_TOP)) u0 (.*);

  typedef struct { int kind; string req; } exp_t;
  exp_t q[$];
  int nchk = 0, nfail = 0, nforce = 0, nhiz = 0;
  string cur_req = "R10";
  bit done = 1'b0;

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // kind: 0 = write accepted, 1 = grant, 2 = reject
  task automatic seen(int kind);
    if (q.size() == 0) chk(1'b0, cur_req, kind, -1);
    else begin
      exp_t e = q.pop_front();
      chk(e.kind == kind, e.req, kind, e.kind);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    if (wr_accept) seen(0);
    if (pe_grant)  seen(1);
    if (pe_reject) seen(2);
    if (force_read) nforce++;
    if (out_hiz) nhiz++;
  end

  task automatic do_write(bit expect_ok, string req, int we_low);
    cur_req = req;
    if (expect_ok) q.push_back('{0, req});
    pin_ce_n = 1'b0; pin_oe_n = 1'b1; cyc(GC + 2);
    pin_we_n = 1'b0; cyc(we_low);
    pin_we_n = 1'b1; cyc(GC + 3);
    pin_ce_n = 1'b1; cyc(GC + 2);
  endtask

  task automatic do_pe(int sect, bit start, bit grant, string req);
    cur_req = req;
    q.push_back('{grant ? 1 : 2, req});
    pe_req = 1'b1; pe_sector = SW'(sect); cmd_start = start;
    cyc(1);
    pe_req = 1'b0; cmd_start = 1'b0;
    cyc(2);
  endtask

  task automatic drain(string req);
    cyc(3);
    chk(q.size() == 0, req, q.size(), 0);
  endtask

  initial begin
    int f0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R10, R11: reset state
    chk({wr_accept, pe_grant, pe_reject, force_read, out_hiz} == 5'b0, "R10",
        {wr_accept, pe_grant, pe_reject, force_read, out_hiz}, 0);
    // R11: captured level defaults to 1, so pin low alone does not lock sector 7
    wp_n = 1'b0;
    do_pe(7, 1'b0, 1'b1, "R11");
    wp_n = 1'b1;
    drain("R11");
    // R1: normal write
    do_write(1'b1, "R1", GC + 2);
    drain("R1");
    do_write(1'b1, "R1", GC);
    drain("R1");
    // R2: WE# glitch of GC-1 clocks
    do_write(1'b0, "R2", GC - 1);
    drain("R2");
    // R2: CE# glitch during a long WE# low
    cur_req = "R2";
    pin_ce_n = 1'b0; pin_we_n = 1'b0; cyc(GC - 1);
    pin_ce_n = 1'b1; cyc(GC + 2);
    pin_we_n = 1'b1; cyc(GC + 3);
    drain("R2");
    // R4: protection bits follow storage when the pin is high
    sect_prot = 8'b1000_0010;
    do_pe(1, 1'b1, 1'b0, "R4");
    do_pe(3, 1'b0, 1'b1, "R4");
    do_pe(7, 1'b0, 1'b0, "R4");
    sect_prot = 8'b0000_0000;
    do_pe(7, 1'b0, 1'b1, "R4");
    // R3: pin low locks sector 7 only
    wp_n = 1'b0;
    do_pe(7, 1'b1, 1'b0, "R3");
    do_pe(0, 1'b0, 1'b1, "R3");
    do_pe(6, 1'b0, 1'b1, "R3");
    // R5: pin change after capture is ignored
    wp_n = 1'b1;
    do_pe(7, 1'b0, 1'b0, "R5");
    do_pe(7, 1'b1, 1'b1, "R5");
    wp_n = 1'b0;
    do_pe(7, 1'b0, 1'b1, "R5");
    wp_n = 1'b1;
    drain("R5");
    // R6, R10: supply low
    f0 = nforce;
    supply_ok = 1'b0; cyc(3);
    chk(nforce == f0 + 1, "R10", nforce - f0, 1);
    do_write(1'b0, "R6", GC + 2);
    do_pe(2, 1'b0, 1'b0, "R6");
    supply_ok = 1'b1; cyc(3);
    drain("R6");
    do_pe(2, 1'b0, 1'b1, "R6");
    drain("R6");
    // R7: WE# held low from power-up
    f0 = nforce;
    cur_req = "R7";
    pwr_up = 1'b1; pin_ce_n = 1'b0; pin_we_n = 1'b0; pin_oe_n = 1'b1;
    cyc(GC + 4);
    chk(nforce == f0 + 1, "R7", nforce - f0, 1);
    pwr_up = 1'b0; cyc(4);
    pin_we_n = 1'b1; cyc(GC + 3);
    pin_ce_n = 1'b1; cyc(GC + 2);
    drain("R7");
    do_write(1'b1, "R7", GC + 2);
    drain("R7");
    // R9: short reset pulse
    nhiz = 0;
    pin_rst_n = 1'b0; cyc(RMIN - 1);
    pin_rst_n = 1'b1; cyc(4);
    chk(nhiz == 0, "R9", nhiz, 0);
    // R8: qualified reset
    f0 = nforce;
    pin_rst_n = 1'b0; cyc(RMIN + 1);
    chk(out_hiz == 1'b1, "R8", out_hiz, 1);
    do_pe(4, 1'b0, 1'b0, "R8");
    do_write(1'b0, "R8", GC + 2);
    chk(nforce == f0 + 1, "R10", nforce - f0, 1);
    pin_rst_n = 1'b1; cyc(2);
    chk(out_hiz == 1'b0, "R8", out_hiz, 0);
    drain("R8");
    do_pe(4, 1'b0, 1'b1, "R8");
    drain("R8");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule